// File: doc/BRIEF.md
# Privileged System-Control Register File

A sixteen-entry, 32-bit control register file reached by coprocessor move instructions. The requester presents the whole instruction word, a flag saying whether the processor runs privileged, and a read strobe, a write strobe or both. The block decodes the register number and the auxiliary fields from the instruction. In the same cycle it answers with accept or reject, and on an accepted read it returns the stored value.

Each register keeps only the bits its write mask allows. Some registers always store zero, whatever is written. A write to the performance-control register whose clock-reset bit is set also clears the clock-count register. Refused accesses never change any register.

Top module: `sysctl_regfile`

## Requirements
- R1: The register number is instruction bits 19:16. The secondary register field is bits 3:0. Opcode A is bits 23:21 and opcode B is bits 7:5.
- R2: An access is rejected if `priv` is low, if the secondary field is nonzero, or if either opcode is nonzero. Otherwise it is accepted. `accept` and `reject` are both low when neither strobe is high.
- R3: Accesses to registers 4 and 5 are always rejected, and those registers stay zero. `rdata` is zero whenever no read is accepted.
- R4: A rejected write changes no register.
- R5: Register 0 keeps only the bits of mask 0x0FFFF77F. When bit CLKRST_BIT (default 2) of the written data is set, the same write clears register 1.
- R6: Register 6 keeps only bits 3:0. Register 14 keeps only bits 31:30.
- R7: Register 10 keeps only the bits of mask 0xC0DF003F.
- R8: Registers 7 and 11 store zero on any write.
- R9: All other registers store the full written word. An accepted read returns the stored value combinationally in the same cycle. A write becomes visible from the next clock edge.
- R10: Reset (`rst_n` low) clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 32 | Coprocessor move instruction word |
| priv | input | 1 | High when the processor is in a privileged mode |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero unless a read is accepted |
| accept | output | 1 | Access accepted |
| reject | output | 1 | Access refused |

## Verification
`accept`, `reject` and `rdata` are combinational, so the bench drives inputs on the falling edge and samples them one time unit later, within the same cycle. Register contents change only at the next rising edge. The bench therefore updates its model at that edge and observes the new state through a later read. Every write, masked write and side effect is confirmed by reading back on the following cycle or later.

// File: rtl/sysctl_regfile.sv
module sysctl_regfile #(
  parameter int DW         = 32,
  parameter int NREG       = 16,
  parameter int CLKRST_BIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   instr,
  input  logic          priv,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          accept,
  output logic          reject
);
  localparam int AW = $clog2(NREG);

  function automatic logic [DW-1:0] wmask(input logic [AW-1:0] i);
    case (i)
      AW'(0):  wmask = DW'(32'h0FFF_F77F);
      AW'(4), AW'(5), AW'(7), AW'(11): wmask = '0;
      AW'(6):  wmask = DW'(32'h0000_000F);
      AW'(10): wmask = DW'(32'hC0DF_003F);
      AW'(14): wmask = DW'(32'hC000_0000);
      default: wmask = '1;
    endcase
  endfunction

  logic [DW-1:0] mem [NREG];
  logic [AW-1:0] sel;
  logic          req, legal;

  assign sel    = instr[16 +: AW];
  assign req    = rd_en | wr_en;
  assign legal  = priv && instr[3:0] == 4'd0 && instr[23:21] == 3'd0 &&
                  instr[7:5] == 3'd0 && sel != AW'(4) && sel != AW'(5);
  assign accept = req & legal;
  assign reject = req & ~legal;
  assign rdata  = (accept && rd_en) ? mem[sel] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (wr_en && accept) begin
      mem[sel] <= wdata & wmask(sel);
      if (sel == AW'(0) && wdata[CLKRST_BIT]) mem[1] <= '0;
    end
  end

  p_user_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !priv) |-> (reject && !accept));
  p_hole_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (sel == AW'(4) || sel == AW'(5))) |-> !accept);
  p_reject_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reject) |=> $stable(mem[NREG-1]));
  p_ctl_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && accept && sel == AW'(0)) |=> (mem[0] & ~DW'(32'h0FFF_F77F)) == '0);
  p_clk_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && accept && sel == AW'(0) && wdata[CLKRST_BIT]) |=> mem[1] == '0);
  p_cfg_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && accept && sel == AW'(6)) |=> mem[6] == ($past(wdata) & DW'(32'hF)));
  p_full_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && accept && sel == AW'(NREG-1)) |=> mem[NREG-1] == $past(wdata));
endmodule

// File: tb/sysctl_regfile_test.sv
module sysctl_regfile_test;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0, priv = 0, rd_en = 0, wr_en = 0;
  logic [31:0] instr = 0, wdata = 0, rdata;
  logic accept, reject;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] model [16];

  sysctl_regfile uut (.clk(clk), .rst_n(rst_n), .instr(instr), .priv(priv),
    .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .accept(accept), .reject(reject));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mask_of(int r);
    case (r)
      0: return 32'h0FFF_F77F;
      4, 5, 7, 11: return 0;
      6: return 32'hF;
      10: return 32'hC0DF_003F;
      14: return 32'hC000_0000;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic bit legal_of(logic [31:0] ins, logic p);
    int r = ins[19:16];
    return p && ins[3:0] == 0 && ins[23:21] == 0 && ins[7:5] == 0 && r != 4 && r != 5;
  endfunction

  function automatic string tag_of(int r);
    case (r)
      0, 1: return "R5";
      6, 14: return "R6";
      10: return "R7";
      7, 11: return "R8";
      4, 5: return "R3";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [31:0] mk(int r, int crm = 0, int o1 = 0, int o2 = 0);
    return (32'(o1) << 21) | (32'(r) << 16) | (32'(o2) << 5) | 32'(crm) | 32'hEE10_0E10 & 32'h0F00_1E10;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(logic [31:0] ins, logic p, logic rd, logic wr, logic [31:0] wd);
    bit lg, rq;
    int r;
    @(negedge clk);
    instr = ins; priv = p; rd_en = rd; wr_en = wr; wdata = wd;
    #1;
    r = ins[19:16]; rq = rd | wr; lg = legal_of(ins, p);
    chk(accept == (rq && lg), "R2", 32'(accept), 32'(rq && lg));
    chk(reject == (rq && !lg), "R2", 32'(reject), 32'(rq && !lg));
    chk(rdata == ((rd && lg) ? model[r] : 32'h0), (rd && lg) ? tag_of(r) : "R3",
        rdata, (rd && lg) ? model[r] : 32'h0);
    @(posedge clk);
    if (wr && lg) begin
      model[r] = wd & mask_of(r);
      if (r == 0 && wd[2]) model[1] = 0;
    end
  endtask

  task automatic read_all();
    for (int r = 0; r < 16; r++) access(mk(r), 1, 1, 0, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R10: everything zero after reset
    read_all();
    // R9: full-width registers, same-cycle read
    access(mk(15), 1, 0, 1, 32'hDEAD_BEEF);
    access(mk(15), 1, 1, 0, 0);
    // R2: user mode and nonzero fields rejected, R4: no state change
    access(mk(15), 0, 0, 1, 32'h1111_1111);
    access(mk(15, 1), 1, 0, 1, 32'h2222_2222);
    access(mk(15, 0, 1), 1, 0, 1, 32'h3333_3333);
    access(mk(15, 0, 0, 7), 1, 0, 1, 32'h4444_4444);
    access(mk(15), 1, 1, 0, 0);
    // R1: field positions
    access(32'h000F_0000, 1, 1, 0, 0);
    access(32'h0000_0010, 1, 1, 0, 0);
    // R3: holes
    access(mk(4), 1, 0, 1, 32'hFFFF_FFFF);
    access(mk(5), 1, 1, 1, 32'hFFFF_FFFF);
    // R5: mask and clock-count clear
    access(mk(1), 1, 0, 1, 32'h1234_5678);
    access(mk(0), 1, 0, 1, 32'hFFFF_FFFB);
    access(mk(1), 1, 1, 0, 0);
    access(mk(0), 1, 0, 1, 32'hFFFF_FFFF);
    access(mk(1), 1, 1, 0, 0);
    access(mk(0), 1, 1, 0, 0);
    // R6 R7 R8
    access(mk(6), 1, 0, 1, 32'hFFFF_FFFF);
    access(mk(14), 1, 0, 1, 32'hFFFF_FFFF);
    access(mk(10), 1, 0, 1, 32'hFFFF_FFFF);
    access(mk(7), 1, 0, 1, 32'hFFFF_FFFF);
    access(mk(11), 1, 0, 1, 32'hFFFF_FFFF);
    read_all();
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(15);
      int crm = ($urandom_range(7) == 0) ? $urandom_range(15) : 0;
      int o1 = ($urandom_range(9) == 0) ? $urandom_range(7) : 0;
      int o2 = ($urandom_range(9) == 0) ? $urandom_range(7) : 0;
      logic p = ($urandom_range(7) != 0);
      logic rd = $urandom_range(1);
      logic wr = $urandom_range(1);
      access(mk(r, crm, o1, o2), p, rd, wr, $urandom());
    end
    read_all();
    @(negedge clk) rst_n = 0;
    @(posedge clk);
    for (int i = 0; i < 16; i++) model[i] = 0;
    @(negedge clk) rst_n = 1;
    read_all();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule